// File: doc/BRIEF.md
# Priority PMP permission checker

This block decides, within one combinational path, whether a memory access may proceed under a set of physical-memory protection entries. It takes the access address, its size in bytes, the requested read/write/execute set and whether the requester runs in machine mode. It also takes every entry's inclusive address range and configuration, and two security-policy bits: a lockdown bit that switches on the enhanced permission table and a whitelist bit that makes unmatched accesses fail. It returns the set of permissions that apply to the access and a pass flag.

The entries are checked in priority order, and entry 0 has the highest priority. The first active entry that touches either end of the access decides the result. If that entry covers only one end, the access is refused outright. If it covers both ends, the entry's permissions are turned into a grant, either by the legacy rule or by the enhanced table. If no active entry touches the access, a default policy chosen by the two security bits applies. Nothing is registered. The outputs follow the inputs in the same cycle, so the checker can sit in the address path of a load/store or fetch unit, next to the range registers that feed it.

Top module: `pmp_priority_checker`

## Requirements
- R1: Each entry has a 6-bit config: bit 0 R, bit 1 W, bit 2 X, bits 4:3 match mode (0 = off, any other value = active), bit 5 lock. An active entry contains byte b when lo <= b <= hi. The access covers the bytes acc_addr through acc_addr + acc_size - 1, computed modulo 2^ADDR_W, and acc_size is 1, 2 or 4. Entries that are off are skipped.
- R2: If the first active entry that contains either end byte of the access contains only one of them, grant is 000 and pass is 0, even when a later entry covers the whole access.
- R3: The lowest-indexed active entry that contains both end bytes decides the result. Entries with higher indices have no effect.
- R4: With the lockdown bit clear, a matching entry grants RWX to a machine-mode access when the entry is unlocked. In every other case it grants the entry's own R/W/X bits.
- R5: With the lockdown bit set and machine mode, the table index is {lock,R,W,X}. Indices 0, 1 and 4 through 8 grant nothing. Indices 2, 3 and 14 grant RW. Indices 9 and 10 grant X. Indices 11 and 13 grant RX. Indices 12 and 15 grant R.
- R6: With the lockdown bit set and a mode other than machine mode, the same index applies. Indices 0, 8, 9, 12, 13 and 14 grant nothing. Indices 1, 10 and 11 grant X. Indices 2, 4 and 15 grant R. Indices 3 and 6 grant RW. Index 5 grants RX. Index 7 grants RWX.
- R7: When an entry matches, pass is 1 exactly when every requested permission bit (acc_req: bit 0 R, bit 1 W, bit 2 X) is also set in grant.
- R8: With no match and the whitelist bit set, grant is 000 and pass is 0 in every mode, machine mode included.
- R9: With no match, the whitelist bit clear and the lockdown bit set, a machine-mode access that does not request X gets grant 011 and pass 1. Every other access gets 000 and fails.
- R10: With no match and both security bits clear, a machine-mode access gets grant 111 and passes. Any other mode gets 000 and fails. This also holds when no entry is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | ADDR_W | Address of the first byte of the access |
| acc_size | input | SIZE_W | Access size in bytes (1, 2 or 4) |
| acc_req | input | 3 | Requested permissions, bit 0 R, bit 1 W, bit 2 X |
| acc_mmode | input | 1 | 1 when the requester is in machine mode |
| ent_lo | input | N_ENT*ADDR_W | Inclusive lower bound of each entry, entry i at bits i*ADDR_W upward |
| ent_hi | input | N_ENT*ADDR_W | Inclusive upper bound of each entry, same packing |
| ent_cfg | input | N_ENT*6 | Config of each entry, entry i at bits i*6 upward |
| sec_mml | input | 1 | Lockdown bit: selects the enhanced table and default |
| sec_mmwp | input | 1 | Whitelist bit: unmatched accesses are denied |
| grant | output | 3 | Permissions that apply to the access |
| pass | output | 1 | 1 when the access is allowed |

## Verification
Directed vectors first place one access at each end of a range and then across a range boundary. This separates a full match from a one-end overlap, and the wrapping last-byte computation is tried at the top of the address space. Stacked entries with different permissions show which entry wins: a narrow high-priority entry inside a wide one, and a high-priority entry that the access only straddles. All sixteen lock/R/W/X combinations are then swept in both modes under the lockdown bit, and the default policy is tried for every combination of the security bits and modes. These vectors are followed by a long run of random overlapping layouts, in which every vector is compared against a behavioural model.

// File: rtl/pmpchk_pkg.sv
package pmpchk_pkg;

  // per-entry configuration layout
  localparam int CFG_W      = 6;
  localparam int CB_R       = 0;
  localparam int CB_W       = 1;
  localparam int CB_X       = 2;
  localparam int CB_AM_LO   = 3;
  localparam int CB_AM_HI   = 4;
  localparam int CB_LOCK    = 5;

  // permission set: bit 0 read, bit 1 write, bit 2 execute
  typedef logic [2:0] perm_t;

  localparam perm_t P_NONE = 3'b000;
  localparam perm_t P_R    = 3'b001;
  localparam perm_t P_RW   = 3'b011;
  localparam perm_t P_X    = 3'b100;
  localparam perm_t P_RX   = 3'b101;
  localparam perm_t P_RWX  = 3'b111;

  // which path decided the result
  typedef enum logic [1:0] {
    SRC_DEFAULT = 2'd0,
    SRC_MATCH   = 2'd1,
    SRC_PARTIAL = 2'd2
  } src_e;

endpackage

// File: rtl/pmpchk_range_cmp.sv
module pmpchk_range_cmp #(
  parameter int ADDR_W = 34
) (
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] first_b,
  input  logic [ADDR_W-1:0] last_b,
  output logic              in_first,
  output logic              in_last
);

  // inclusive bounds; lo > hi describes an empty range
  assign in_first = (first_b >= lo) && (first_b <= hi);
  assign in_last  = (last_b  >= lo) && (last_b  <= hi);

endmodule

// File: rtl/pmpchk_prio_select.sv
module pmpchk_prio_select #(
  parameter int N_ENT = 8
) (
  input  logic [N_ENT-1:0] active,
  input  logic [N_ENT-1:0] in_first,
  input  logic [N_ENT-1:0] in_last,
  output logic [N_ENT-1:0] sel,
  output logic             any_hit,
  output logic             full_hit
);

  logic [N_ENT-1:0] touch;
  assign touch = active & (in_first | in_last);

  // lowest index touching either end byte wins
  always_comb begin
    sel      = '0;
    any_hit  = 1'b0;
    full_hit = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!any_hit && touch[i]) begin
        sel[i]   = 1'b1;
        any_hit  = 1'b1;
        full_hit = in_first[i] && in_last[i];
      end
    end
  end

  always_comb begin
    // R3
    sel_onehot_chk: assert ($onehot0(sel))
      else $error("selection not one-hot");
    // R3
    sel_presence_chk: assert (any_hit == (|touch))
      else $error("selection presence mismatch");
  end

endmodule

// File: rtl/pmpchk_perm_decode.sv
module pmpchk_perm_decode
  import pmpchk_pkg::*;
(
  input  logic  lock,
  input  perm_t rwx,
  input  logic  mmode,
  input  logic  mml,
  output perm_t grant
);

  logic [3:0] idx;
  perm_t      legacy_g;
  perm_t      mtab_g;
  perm_t      utab_g;

  assign idx = {lock, rwx[0], rwx[1], rwx[2]};

  assign legacy_g = (mmode && !lock) ? P_RWX : rwx;

  always_comb begin
    unique case (idx)
      4'd2, 4'd3, 4'd14: mtab_g = P_RW;
      4'd9, 4'd10:       mtab_g = P_X;
      4'd11, 4'd13:      mtab_g = P_RX;
      4'd12, 4'd15:      mtab_g = P_R;
      default:           mtab_g = P_NONE;
    endcase
  end

  always_comb begin
    unique case (idx)
      4'd1, 4'd10, 4'd11: utab_g = P_X;
      4'd2, 4'd4, 4'd15:  utab_g = P_R;
      4'd3, 4'd6:         utab_g = P_RW;
      4'd5:               utab_g = P_RX;
      4'd7:               utab_g = P_RWX;
      default:            utab_g = P_NONE;
    endcase
  end

  assign grant = !mml ? legacy_g : (mmode ? mtab_g : utab_g);

  always_comb begin
    // R5
    mml_mmode_not_full_chk: assert (!(mml && mmode) || (grant != P_RWX))
      else $error("machine mode got full access under lockdown");
    // R6
    mml_user_locked_nowrite_chk: assert (!(mml && !mmode && lock) || !grant[1])
      else $error("locked entry gave write to lower mode");
    // R4
    legacy_unlocked_m_chk: assert (!(!mml && mmode && !lock) || (grant == P_RWX))
      else $error("unlocked entry restricted machine mode");
  end

endmodule

// File: rtl/pmpchk_default_policy.sv
module pmpchk_default_policy
  import pmpchk_pkg::*;
(
  input  logic  mmode,
  input  logic  req_x,
  input  logic  mml,
  input  logic  mmwp,
  output perm_t grant,
  output logic  ok
);

  always_comb begin
    if (mmwp) begin
      grant = P_NONE;
      ok    = 1'b0;
    end else if (mml) begin
      grant = (mmode && !req_x) ? P_RW : P_NONE;
      ok    = mmode && !req_x;
    end else begin
      grant = mmode ? P_RWX : P_NONE;
      ok    = mmode;
    end
  end

  always_comb begin
    // R8
    mmwp_deny_chk: assert (!mmwp || (!ok && grant == P_NONE))
      else $error("whitelist default allowed an access");
    // R9
    mml_no_exec_chk: assert (!(mml && ok) || !grant[2])
      else $error("lockdown default granted execute");
  end

endmodule

// File: rtl/pmp_priority_checker.sv
module pmp_priority_checker
  import pmpchk_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 34,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [SIZE_W-1:0]       acc_size,
  input  logic [2:0]              acc_req,
  input  logic                    acc_mmode,
  input  logic [N_ENT*ADDR_W-1:0] ent_lo,
  input  logic [N_ENT*ADDR_W-1:0] ent_hi,
  input  logic [N_ENT*CFG_W-1:0]  ent_cfg,
  input  logic                    sec_mml,
  input  logic                    sec_mmwp,
  output logic [2:0]              grant,
  output logic                    pass
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] last_b;
  logic [N_ENT-1:0]  active;
  logic [N_ENT-1:0]  in_first;
  logic [N_ENT-1:0]  in_last;
  logic [N_ENT-1:0]  sel;
  logic              any_hit;
  logic              full_hit;
  logic              sel_lock;
  perm_t             sel_rwx;
  perm_t             dec_grant;
  perm_t             def_grant;
  logic              def_ok;
  src_e              src;

  // last byte wraps within the address space
  assign last_b = acc_addr + ADDR_W'(acc_size) - ONE;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic [CFG_W-1:0] cfg_i;
    assign cfg_i     = ent_cfg[i*CFG_W +: CFG_W];
    assign active[i] = |cfg_i[CB_AM_HI:CB_AM_LO];

    pmpchk_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .lo       (ent_lo[i*ADDR_W +: ADDR_W]),
      .hi       (ent_hi[i*ADDR_W +: ADDR_W]),
      .first_b  (acc_addr),
      .last_b   (last_b),
      .in_first (in_first[i]),
      .in_last  (in_last[i])
    );
  end

  pmpchk_prio_select #(.N_ENT(N_ENT)) u_sel (
    .active   (active),
    .in_first (in_first),
    .in_last  (in_last),
    .sel      (sel),
    .any_hit  (any_hit),
    .full_hit (full_hit)
  );

  // one-hot mux of the winning entry's lock and permission bits
  always_comb begin
    sel_lock = 1'b0;
    sel_rwx  = P_NONE;
    for (int i = 0; i < N_ENT; i++) begin
      if (sel[i]) begin
        sel_lock = sel_lock | ent_cfg[i*CFG_W + CB_LOCK];
        sel_rwx  = sel_rwx | {ent_cfg[i*CFG_W + CB_X],
                              ent_cfg[i*CFG_W + CB_W],
                              ent_cfg[i*CFG_W + CB_R]};
      end
    end
  end

  pmpchk_perm_decode u_dec (
    .lock  (sel_lock),
    .rwx   (sel_rwx),
    .mmode (acc_mmode),
    .mml   (sec_mml),
    .grant (dec_grant)
  );

  pmpchk_default_policy u_def (
    .mmode (acc_mmode),
    .req_x (acc_req[2]),
    .mml   (sec_mml),
    .mmwp  (sec_mmwp),
    .grant (def_grant),
    .ok    (def_ok)
  );

  always_comb begin
    if (!any_hit)      src = SRC_DEFAULT;
    else if (full_hit) src = SRC_MATCH;
    else               src = SRC_PARTIAL;
  end

  always_comb begin
    unique case (src)
      SRC_MATCH: begin
        grant = dec_grant;
        pass  = (acc_req & dec_grant) == acc_req;
      end
      SRC_PARTIAL: begin
        grant = P_NONE;
        pass  = 1'b0;
      end
      default: begin
        grant = def_grant;
        pass  = def_ok;
      end
    endcase
  end

  always_comb begin
    // R2
    partial_fail_chk: assert (!(any_hit && !full_hit) || (grant == P_NONE && !pass))
      else $error("partial overlap did not fail");
    // R7
    pass_subset_chk: assert (!pass || ((acc_req & ~grant) == 3'b000))
      else $error("pass without every requested permission");
    // R10
    legacy_default_chk: assert (any_hit || sec_mml || sec_mmwp || (pass == acc_mmode))
      else $error("legacy default mode rule broken");
  end

endmodule

// File: tb/sim_pmp_priority_checker.sv
module sim_pmp_priority_checker;

  localparam int N  = 8;
  localparam int AW = 34;
  localparam int SW = 3;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [AW-1:0]   acc_addr;
  logic [SW-1:0]   acc_size;
  logic [2:0]      acc_req;
  logic            acc_mmode;
  logic [N*AW-1:0] ent_lo;
  logic [N*AW-1:0] ent_hi;
  logic [N*CW-1:0] ent_cfg;
  logic            sec_mml;
  logic            sec_mmwp;
  logic [2:0]      grant;
  logic            pass;

  int nvec = 0;
  int nbad = 0;

  pmp_priority_checker #(.N_ENT(N), .ADDR_W(AW), .SIZE_W(SW)) u0 (
    .acc_addr (acc_addr), .acc_size (acc_size), .acc_req (acc_req),
    .acc_mmode(acc_mmode), .ent_lo (ent_lo), .ent_hi (ent_hi),
    .ent_cfg  (ent_cfg), .sec_mml (sec_mml), .sec_mmwp (sec_mmwp),
    .grant    (grant), .pass (pass)
  );

  // machine-mode and lower-mode tables, indexed by {lock,R,W,X}
  int mtab [16] = '{0,0,3,3,0,0,0,0,0,4,4,5,1,5,3,1};
  int utab [16] = '{0,4,1,3,1,5,3,7,0,0,4,4,0,0,0,1};

  function automatic logic [5:0] mkcfg(bit lk, int am, bit x, bit w, bit r);
    return {lk, 2'(am), x, w, r};
  endfunction

  task automatic clear_all();
    ent_lo = '0; ent_hi = '0; ent_cfg = '0;
    sec_mml = 0; sec_mmwp = 0;
    acc_addr = '0; acc_size = 3'd1; acc_req = 3'b000; acc_mmode = 0;
  endtask

  task automatic set_ent(int i, longint lo, longint hi, logic [5:0] c);
    ent_lo[i*AW +: AW]  = AW'(lo);
    ent_hi[i*AW +: AW]  = AW'(hi);
    ent_cfg[i*CW +: CW] = c;
  endtask

  task automatic set_acc(longint a, int sz, logic [2:0] rq, bit m);
    acc_addr = AW'(a); acc_size = SW'(sz); acc_req = rq; acc_mmode = m;
  endtask

  // behavioural reference
  function automatic void ref_eval(output logic [2:0] g, output logic p);
    longint unsigned mask = (64'd1 << AW) - 1;
    longint unsigned a = acc_addr;
    longint unsigned e = (a + acc_size - 1) & mask;
    for (int i = 0; i < N; i++) begin
      logic [5:0] c = ent_cfg[i*CW +: CW];
      longint unsigned lo = ent_lo[i*AW +: AW];
      longint unsigned hi = ent_hi[i*AW +: AW];
      bit f, l;
      if (c[4:3] == 2'b00) continue;
      f = (a >= lo) && (a <= hi);
      l = (e >= lo) && (e <= hi);
      if (f != l) begin g = 3'b000; p = 0; return; end
      if (f) begin
        int k = {c[5], c[0], c[1], c[2]};
        if (!sec_mml) g = (acc_mmode && !c[5]) ? 3'b111 : c[2:0];
        else if (acc_mmode) g = 3'(mtab[k]);
        else g = 3'(utab[k]);
        p = ((acc_req & g) == acc_req);
        return;
      end
    end
    if (sec_mmwp) begin g = 3'b000; p = 0; end
    else if (sec_mml) begin
      p = acc_mmode && !acc_req[2];
      g = p ? 3'b011 : 3'b000;
    end else begin
      p = acc_mmode;
      g = p ? 3'b111 : 3'b000;
    end
  endfunction

  // apply current inputs for one clock, sample away from the edge
  task automatic apply(string tag);
    logic [2:0] eg;
    logic ep;
    @(posedge clk);
    #2;
    ref_eval(eg, ep);
    nvec++;
    if (grant !== eg || pass !== ep) begin
      nbad++;
      $display("FAIL %s: grant=%b pass=%b expected grant=%b pass=%b",
               tag, grant, pass, eg, ep);
    end
  endtask

  // fixed-value check against hand-computed expectation as well
  task automatic expect_v(string tag, logic [2:0] eg, logic ep);
    apply(tag);
    nvec++;
    if (grant !== eg || pass !== ep) begin
      nbad++;
      $display("FAIL %s (fixed): grant=%b pass=%b expected grant=%b pass=%b",
               tag, grant, pass, eg, ep);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // reset state, no entries active: R10
    set_acc(0, 1, 3'b111, 1);  expect_v("R10 reset m-mode", 3'b111, 1);
    set_acc(0, 1, 3'b001, 0);  expect_v("R10 reset user", 3'b000, 0);

    // R1 bounds and wrap
    clear_all();
    set_ent(0, 'h100, 'h1FF, mkcfg(0, 1, 0, 1, 1));
    set_acc('h1FC, 4, 3'b011, 0); expect_v("R1 top full", 3'b011, 1);
    set_acc('h1FF, 1, 3'b001, 0); expect_v("R1 last byte", 3'b011, 1);
    set_acc('h100, 2, 3'b001, 0); expect_v("R1 first byte", 3'b011, 1);
    set_acc('h1FD, 4, 3'b001, 0); expect_v("R2 straddle top", 3'b000, 0);
    set_acc('h0FF, 2, 3'b001, 0); expect_v("R2 straddle bottom", 3'b000, 0);
    set_ent(0, 'h100, 'h1FF, mkcfg(0, 0, 0, 1, 1));
    set_acc('h1FD, 4, 3'b001, 0); expect_v("R1 off entry skipped", 3'b000, 0);
    set_acc('h1FD, 4, 3'b111, 1); expect_v("R1 off entry skipped m", 3'b111, 1);
    set_ent(0, 'h3_FFFF_FFF0, 'h3_FFFF_FFFF, mkcfg(0, 3, 1, 0, 1));
    set_acc('h3_FFFF_FFFE, 4, 3'b001, 0); expect_v("R1 wrap last byte", 3'b000, 0);
    set_acc('h3_FFFF_FFFC, 4, 3'b101, 0); expect_v("R1 top of space", 3'b101, 1);

    // R3 priority
    clear_all();
    set_ent(0, 'h100, 'h10F, mkcfg(0, 1, 0, 0, 1));
    set_ent(1, 'h000, 'hFFF, mkcfg(0, 2, 1, 1, 1));
    set_acc('h104, 4, 3'b010, 0); expect_v("R3 narrow wins", 3'b001, 0);
    set_acc('h104, 4, 3'b001, 0); expect_v("R7 read allowed", 3'b001, 1);
    set_acc('h200, 4, 3'b010, 0); expect_v("R3 wide applies", 3'b111, 1);
    set_acc('h10E, 4, 3'b001, 0); expect_v("R2 partial beats later full", 3'b000, 0);
    set_acc('h200, 4, 3'b000, 0); expect_v("R7 empty request", 3'b111, 1);

    // R4 legacy
    clear_all();
    set_ent(2, 'h40, 'h7F, mkcfg(0, 1, 0, 0, 1));
    set_acc('h40, 4, 3'b111, 1); expect_v("R4 unlocked m-mode", 3'b111, 1);
    set_ent(2, 'h40, 'h7F, mkcfg(1, 1, 0, 0, 1));
    set_acc('h40, 4, 3'b010, 1); expect_v("R4 locked m-mode", 3'b001, 0);
    set_acc('h40, 4, 3'b001, 0); expect_v("R4 user mode", 3'b001, 1);

    // R5 / R6 sweep of every table index
    for (int k = 0; k < 16; k++) begin
      clear_all();
      sec_mml = 1;
      set_ent(0, 'h80, 'hBF, mkcfg(k[3], 1, k[0], k[1], k[2]));
      set_acc('h80, 4, 3'b000, 1);
      expect_v($sformatf("R5 idx %0d", k), 3'(mtab[k]), 1);
      set_acc('h80, 4, 3'b000, 0);
      expect_v($sformatf("R6 idx %0d", k), 3'(utab[k]), 1);
      set_acc('h80, 4, 3'b111, 0);
      apply($sformatf("R7 idx %0d", k));
    end

    // R8 whitelist default
    clear_all();
    set_ent(0, 'h80, 'hBF, mkcfg(0, 1, 1, 1, 1));
    sec_mmwp = 1;
    set_acc('h400, 1, 3'b001, 1); expect_v("R8 m-mode denied", 3'b000, 0);
    sec_mml = 1;
    set_acc('h400, 1, 3'b001, 1); expect_v("R8 over lockdown", 3'b000, 0);

    // R9 lockdown default
    sec_mmwp = 0;
    set_acc('h400, 1, 3'b011, 1); expect_v("R9 m-mode rw", 3'b011, 1);
    set_acc('h400, 1, 3'b100, 1); expect_v("R9 m-mode exec", 3'b000, 0);
    set_acc('h400, 1, 3'b001, 0); expect_v("R9 user", 3'b000, 0);

    // R10 legacy default with active entry
    sec_mml = 0;
    set_acc('h400, 1, 3'b111, 1); expect_v("R10 m-mode", 3'b111, 1);
    set_acc('h400, 1, 3'b001, 0); expect_v("R10 user", 3'b000, 0);

    // random overlapping layouts
    for (int n = 0; n < 3000; n++) begin
      int szsel;
      clear_all();
      for (int i = 0; i < N; i++) begin
        int lo = $urandom_range(0, 511);
        int hi = lo + $urandom_range(0, 127) - (($urandom_range(0, 9) == 0) ? 130 : 0);
        set_ent(i, lo, hi, 6'($urandom));
      end
      szsel = $urandom_range(0, 2);
      set_acc($urandom_range(0, 700), (szsel == 0) ? 1 : (szsel == 1) ? 2 : 4,
              3'($urandom), bit'($urandom));
      sec_mml  = bit'($urandom);
      sec_mmwp = ($urandom_range(0, 3) == 0);
      apply("R1-random R3 R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule